// File: doc/BRIEF.md
# Interrupt trigger configuration packer

This block holds the edge-or-level choice for a bank of interrupts and presents it to software as configuration words with two bits per interrupt. A 32-bit configuration word therefore describes sixteen interrupts, while the block itself keeps only one bit per interrupt. A stored 1 means edge-triggered and a stored 0 means level-sensitive. The full stored vector is driven out on `edge_sel` for the pending logic.

On a read, the sixteen stored bits of the addressed word are spread onto the odd bit positions of `rd_data`. On a write, the odd bits of `wr_data` are gathered into sixteen bits, and those bits replace the addressed group of sixteen interrupts. Seen as 32-bit storage words, each configuration word fills one half of a storage word. Bit 0 of the word index picks the half. Words that cover interrupts below 32, and words at or beyond the implemented interrupt count, read as zero and ignore writes.

Top module: `trig_cfg_packer`

## Requirements
- R1: Configuration word k covers interrupts 16k to 16k+15. The setting of interrupt 16k+i is returned on bit 2i+1 of `rd_data` while `cfg_idx` is k. The read is combinational.
- R2: Every even bit of `rd_data` is always 0, and the even bits of `wr_data` have no effect on the stored state.
- R3: A write (`wr_en`=1) to a valid word k updates interrupts 16k..16k+15 from the odd bits of `wr_data` at the next rising clock edge. Bit 2i+1 goes to interrupt 16k+i, and 1 means edge-triggered.
- R4: A write changes no interrupt outside its own sixteen. In particular, the other half of the same 32-bit storage word keeps its value.
- R5: Words 0 and 1 (interrupts 0..31) read as zero and ignore writes, so `edge_sel[31:0]` stays 0.
- R6: Words with index NUM_IRQ/16 or above read as zero, and writes to them have no effect.
- R7: After reset every interrupt is level-sensitive, so `edge_sel` is all zeros.
- R8: `edge_sel` bit n is the stored setting of interrupt n. With `wr_en`=0 it holds its value whatever `cfg_idx` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| cfg_idx | input | IDX_W | Configuration word index (first interrupt = 16 * index) |
| wr_data | input | 32 | Write data, odd bits used |
| rd_data | output | 32 | Read data of the addressed word |
| edge_sel | output | NUM_IRQ | Per-interrupt edge (1) or level (0) selection |

## Verification
The assertions assume that `wr_en` and `cfg_idx` are settled before each rising edge. The write-then-read check also assumes that a read of the same word in the cycle after a write sees the new value, which holds only when the index is held. The bench therefore drives every input on the falling edge and keeps the index steady across the edge where a write lands. It sweeps every index, including those that are out of range, with random data. After each write it reads all words back and compares `edge_sel` against an arithmetic model.

// File: rtl/trig_cfg_packer.sv
module trig_cfg_packer #(
  parameter int NUM_IRQ = 96,
  parameter int IDX_W   = $clog2(NUM_IRQ / 16) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  output logic [NUM_IRQ-1:0] edge_sel
);
  localparam int NWORDS   = NUM_IRQ / 16;
  localparam int FIRST    = 2;
  localparam logic [31:0] ODD_MASK = 32'hAAAA_AAAA;

  logic [NUM_IRQ-1:0] edge_q;
  logic [15:0]        wr_half, rd_half;
  logic               idx_ok, wr_ok;
  logic [NUM_IRQ-1:0] tgt_mask;

  assign idx_ok = (cfg_idx >= IDX_W'(FIRST)) && (cfg_idx < IDX_W'(NWORDS));
  assign wr_ok  = wr_en && idx_ok;

  // Storage word = cfg_idx >> 1, half = cfg_idx[0]; flat vector keeps both.
  always_comb begin
    rd_half = '0;
    for (int w = FIRST; w < NWORDS; w++)
      if (cfg_idx == IDX_W'(w)) rd_half = edge_q[16*w +: 16];
  end

  for (genvar i = 0; i < 16; i++) begin : g_pack
    assign wr_half[i]      = wr_data[2*i+1];
    assign rd_data[2*i+1]  = rd_half[i];
    assign rd_data[2*i]    = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
    end else if (wr_ok) begin
      for (int w = FIRST; w < NWORDS; w++)
        if (cfg_idx == IDX_W'(w)) edge_q[16*w +: 16] <= wr_half;
    end
  end

  assign edge_sel = edge_q;
  assign tgt_mask = wr_ok ? ({{(NUM_IRQ-16){1'b0}}, 16'hFFFF} << (16 * cfg_idx)) : '0;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_ok) && $stable(cfg_idx)) |-> rd_data == ($past(wr_data) & ODD_MASK)); // R3
  AST_OTHERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_sel ^ $past(edge_sel)) & ~$past(tgt_mask)) == '0); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(edge_sel)); // R8
  AST_OOR_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_ok |-> rd_data == 32'h0); // R6
  AST_LOW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    edge_sel[31:0] == 32'h0); // R5
endmodule

// File: tb/tb_trig_cfg_packer.sv
module tb_trig_cfg_packer;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_IRQ = 96;
  localparam int IDX_W = $clog2(NUM_IRQ / 16) + 1;
  localparam int NIDX = 1 << IDX_W;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [NUM_IRQ-1:0] edge_sel;
  logic [NUM_IRQ-1:0] model = '0;
  int checks = 0, errors = 0;

  trig_cfg_packer #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cfg_idx(cfg_idx),
    .wr_data(wr_data), .rd_data(rd_data), .edge_sel(edge_sel));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_rd(int k);
    logic [31:0] r = '0;
    if (k >= 2 && k < NUM_IRQ/16)
      for (int i = 0; i < 16; i++) r[2*i+1] = model[16*k+i];
    return r;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write(int k, logic [31:0] d, logic en);
    @(negedge clk);
    wr_en = en; cfg_idx = IDX_W'(k); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (en && k >= 2 && k < NUM_IRQ/16)
      for (int i = 0; i < 16; i++) model[16*k+i] = d[2*i+1];
  endtask

  task automatic sweep(string req);
    for (int k = 0; k < NIDX; k++) begin
      cfg_idx = IDX_W'(k);
      #1;
      chk(req, 128'(rd_data), 128'(exp_rd(k)));
      chk("R2 even bits zero", 128'(rd_data & 32'h5555_5555), 128'(0));
    end
    chk({req, " R8 edge_sel"}, 128'(edge_sel), 128'(model));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk("R7 reset level", 128'(edge_sel), 128'(0));
    rst_n = 1;
    @(negedge clk);
    sweep("R7 reset reads");
    // R3/R4: fill word 2, then write its neighbour half (word 3)
    write(2, 32'hFFFF_FFFF, 1);
    sweep("R3 word2 set");
    write(3, 32'h0000_0000, 1);
    sweep("R4 word2 kept after word3");
    chk("R4 direct", 128'(edge_sel[47:32]), 128'(16'hFFFF));
    // R2: even bits only written -> nothing stored
    write(4, 32'h5555_5555, 1);
    sweep("R2 even write ignored");
    // R5/R6 low and out-of-range words
    write(0, 32'hFFFF_FFFF, 1);
    write(1, 32'hAAAA_AAAA, 1);
    sweep("R5 low words RAZ/WI");
    for (int k = NUM_IRQ/16; k < NIDX; k++) write(k, 32'hFFFF_FFFF, 1);
    sweep("R6 out of range RAZ/WI");
    // R8: data on bus without strobe
    write(5, 32'hAAAA_AAAA, 0);
    sweep("R8 no strobe no change");
    // R1/R3: random sweeps over every index
    for (int n = 0; n < 64; n++) begin
      write(n % NIDX, $urandom, 1);
      sweep("R1 R3 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule